// File: doc/BRIEF.md
# Registered Barrel Shifter with Flag Rotate

This block shifts or rotates a 32-bit operand, or the low 16 bits of it, in a single pass and registers the outcome. It offers arithmetic shifts (with an optional clamp on left-shift overflow), logical shifts, a rotate that runs through an external one-bit condition flag, and two fused forms that combine a left shift of one or two places with an addition.

The shift count is a 6-bit two's-complement value taken either from an immediate field or from a register field. A positive count shifts left and a negative count shifts right. The caller supplies the current condition flag and receives the updated flag, the result and an overflow indication one clock after the request.

Top module: `bsh_unit`

## Requirements
- R1: A request is accepted when `in_valid` is 1. `out_valid`, `result`, `flag_out` and `ovf` update on the next rising clock edge, and `out_valid` equals `in_valid` from the previous cycle. When `in_valid` is 0, `result`, `flag_out` and `ovf` keep their values. Reset (`rst_n` low) clears all four outputs to 0.
- R2: The count is `imm_amt` when `use_imm` is 1, otherwise `reg_amt`. Both are 6-bit two's complement. A value of 0 or more shifts left and a negative value shifts right by its magnitude (0 to 32). Operation codes: 0 arithmetic shift, 1 logical shift, 2 rotate, 3 shift-then-add, 4 add-then-shift.
- R3: A logical shift fills vacated bits with 0. A magnitude equal to or above the operand width gives 0.
- R4: An arithmetic right shift fills vacated bits with copies of the sign bit. A magnitude equal to or above the width gives all sign bits.
- R5: An arithmetic left shift fills with 0 and sets `ovf` when the shifted value, shifted back arithmetically, differs from the operand, that is when any bit unequal to the sign passes through the sign position. Without saturation the result equals the logical left shift.
- R6: With `sat` set and `ovf` raised by an arithmetic left shift, the result clamps to the most positive value (0x7FFFFFFF, or 0x7FFF in half mode) for a non-negative operand, and to the most negative value (0x80000000 or 0x8000) for a negative one.
- R7: A rotate treats {flag, operand} as a (width+1)-bit ring and rotates it by the magnitude in the count's direction. `flag_out` is the bit that lands in the flag position: the last bit shifted out. Rotating 0xABCDEF12 left by 4 with the flag at 0 gives 0xABCDEF12 to 0xBCDEF125 and flag 0.
- R8: For every operation other than rotate, `flag_out` equals `flag_in`. `ovf` is 0 for every operation other than arithmetic shift. Codes 5 to 7 give a result of 0.
- R9: Shift-then-add gives (opa << k) + opb, modulo 2^width. k is 2 when the count magnitude is 2 or more, and 1 otherwise.
- R10: Add-then-shift gives (opa + opb) << k, modulo 2^width, with k chosen as in R9.
- R11: With `half` set, only bits 15:0 of `opa` and `opb` take part, the width is 16, and `result[31:16]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (R2) |
| half | input | 1 | 1: 16-bit operand in bits 15:0 |
| use_imm | input | 1 | 1: count from imm_amt, 0: from reg_amt |
| imm_amt | input | 6 | Signed immediate count |
| reg_amt | input | 6 | Signed register count field |
| sat | input | 1 | Clamp arithmetic left-shift overflow |
| flag_in | input | 1 | Current condition flag |
| opa | input | 32 | Operand to shift |
| opb | input | 32 | Addend for fused shift/add |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Registered result |
| flag_out | output | 1 | Updated condition flag |
| ovf | output | 1 | Arithmetic left-shift overflow |

## Verification
The bench builds the block with its default 32-bit word and 6-bit count. With these values every signed count from -32 to 31 is reachable in both widths. That range covers the flush boundary at and beyond the width, the full 33-bit and 17-bit rotate rings, and the count wrap of the 17-bit ring. The sweep crosses every count with each operation code, both widths, both saturation settings and both flag values, over operands chosen to hit sign boundaries. It adds directed cases for count-source selection, idle holding and reset.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
  typedef enum logic [2:0] {
    OP_ASH   = 3'd0,
    OP_LSH   = 3'd1,
    OP_ROT   = 3'd2,
    OP_SHADD = 3'd3,
    OP_ADDSH = 3'd4
  } bsh_op_e;
endpackage

// File: rtl/bsh_amount.sv
module bsh_amount #(
  parameter int CNT_W = 6
) (
  input  logic             use_imm,
  input  logic [CNT_W-1:0] imm_amt,
  input  logic [CNT_W-1:0] reg_amt,
  output logic             left,
  output logic [CNT_W-1:0] mag,
  output logic             step2
);
  logic [CNT_W-1:0] amt;

  function automatic logic [CNT_W-1:0] f_mag(input logic [CNT_W-1:0] a);
    return a[CNT_W-1] ? (~a + 1'b1) : a;
  endfunction

  assign amt   = use_imm ? imm_amt : reg_amt;
  assign left  = ~amt[CNT_W-1];
  assign mag   = f_mag(amt);
  assign step2 = (mag >= CNT_W'(2));
endmodule

// File: rtl/bsh_lane.sv
module bsh_lane
  import bsh_pkg::*;
#(
  parameter int N     = 32,
  parameter int CNT_W = 6
) (
  input  logic [N-1:0]     x,
  input  logic [N-1:0]     b,
  input  logic             flag_i,
  input  bsh_op_e          op,
  input  logic             sat,
  input  logic             left,
  input  logic [CNT_W-1:0] mag,
  input  logic             step2,
  output logic [N-1:0]     y,
  output logic             flag_o,
  output logic             ovf,
  output logic             sat_hit
);
  localparam int unsigned RW = N + 1;
  localparam logic [CNT_W:0] NL = (CNT_W+1)'(N);

  function automatic logic flush(input logic [CNT_W-1:0] m);
    return {1'b0, m} >= NL;
  endfunction

  function automatic logic [N-1:0] f_lsh(input logic [N-1:0] v, input logic l,
                                        input logic [CNT_W-1:0] m);
    if (flush(m)) return '0;
    return l ? (v << m) : (v >> m);
  endfunction

  function automatic logic [N-1:0] f_asr(input logic [N-1:0] v, input logic [CNT_W-1:0] m);
    logic [N-1:0] r;
    if (flush(m)) return {N{v[N-1]}};
    r = $signed(v) >>> m;
    return r;
  endfunction

  function automatic logic f_asl_ovf(input logic [N-1:0] v, input logic [CNT_W-1:0] m);
    logic [N-1:0] s, back;
    if (flush(m)) return v != '0;
    s    = v << m;
    back = $signed(s) >>> m;
    return back != v;
  endfunction

  function automatic logic [N-1:0] f_shl12(input logic [N-1:0] v, input logic two);
    return two ? {v[N-3:0], 2'b00} : {v[N-2:0], 1'b0};
  endfunction

  logic [RW-1:0]   ring, ring_new;
  logic [2*RW-1:0] dbl, dbl_sh;
  logic [31:0]     rot_n32;
  logic [CNT_W-1:0] rot_n;
  logic            asl_ovf;
  logic [N-1:0]    sum_ab;

  assign ring    = {flag_i, x};
  assign dbl     = {ring, ring};
  assign rot_n32 = 32'(mag) % RW;
  assign rot_n   = rot_n32[CNT_W-1:0];
  assign dbl_sh  = left ? (dbl << rot_n) : (dbl >> rot_n);
  assign ring_new = left ? dbl_sh[2*RW-1:RW] : dbl_sh[RW-1:0];
  assign asl_ovf = f_asl_ovf(x, mag);
  assign sum_ab  = x + b;

  always_comb begin
    y       = '0;
    flag_o  = flag_i;
    ovf     = 1'b0;
    sat_hit = 1'b0;
    unique case (op)
      OP_ASH: begin
        if (left) begin
          ovf = asl_ovf;
          if (asl_ovf && sat) begin
            sat_hit = 1'b1;
            y = x[N-1] ? {1'b1, {(N-1){1'b0}}} : {1'b0, {(N-1){1'b1}}};
          end else begin
            y = f_lsh(x, 1'b1, mag);
          end
        end else begin
          y = f_asr(x, mag);
        end
      end
      OP_LSH:   y = f_lsh(x, left, mag);
      OP_ROT: begin
        y      = ring_new[N-1:0];
        flag_o = ring_new[N];
      end
      OP_SHADD: y = f_shl12(x, step2) + b;
      OP_ADDSH: y = f_shl12(sum_ab, step2);
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/bsh_unit.sv
module bsh_unit
  import bsh_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op,
  input  logic             half,
  input  logic             use_imm,
  input  logic [CNT_W-1:0] imm_amt,
  input  logic [CNT_W-1:0] reg_amt,
  input  logic             sat,
  input  logic             flag_in,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             flag_out,
  output logic             ovf
);
  localparam int HW = W / 2;

  logic             left, step2;
  logic [CNT_W-1:0] mag;
  bsh_op_e          op_e;

  logic [W-1:0] lane_y   [2];
  logic         lane_f   [2];
  logic         lane_ov  [2];
  logic         lane_sat [2];

  logic [W-1:0] sel_y;
  logic         sel_f, sel_ov;
  logic         sat_evt;

  assign op_e = bsh_op_e'(op);

  bsh_amount #(.CNT_W(CNT_W)) u_amt (
    .use_imm(use_imm), .imm_amt(imm_amt), .reg_amt(reg_amt),
    .left(left), .mag(mag), .step2(step2)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = (g == 0) ? W : HW;
    logic [LW-1:0] y_g;
    bsh_lane #(.N(LW), .CNT_W(CNT_W)) u_lane (
      .x(opa[LW-1:0]), .b(opb[LW-1:0]), .flag_i(flag_in), .op(op_e),
      .sat(sat), .left(left), .mag(mag), .step2(step2),
      .y(y_g), .flag_o(lane_f[g]), .ovf(lane_ov[g]), .sat_hit(lane_sat[g])
    );
    assign lane_y[g] = W'(y_g);
  end

  assign sel_y   = half ? lane_y[1]   : lane_y[0];
  assign sel_f   = half ? lane_f[1]   : lane_f[0];
  assign sel_ov  = half ? lane_ov[1]  : lane_ov[0];
  assign sat_evt = in_valid & (half ? lane_sat[1] : lane_sat[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_out  <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= sel_y;
        flag_out <= sel_f;
        ovf      <= sel_ov;
      end
    end
  end
endmodule

// File: rtl/bsh_unit_chk.sv
module bsh_unit_chk #(
  parameter int W     = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       op,
  input logic             half,
  input logic             flag_in,
  input logic [W-1:0]     opa,
  input logic             out_valid,
  input logic [W-1:0]     result,
  input logic             flag_out,
  input logic             ovf,
  input logic [CNT_W-1:0] mag,
  input logic             sat_evt
);
  localparam int HW = W / 2;

  logic [W-1:0] exp_sat;
  logic [W-1:0] opa_fit;

  assign exp_sat = half ?
      W'(opa[HW-1] ? {1'b1, {(HW-1){1'b0}}} : {1'b0, {(HW-1){1'b1}}}) :
      (opa[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}});
  assign opa_fit = half ? W'(opa[HW-1:0]) : opa;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(flag_out) && $stable(ovf)); // R1

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && half |=> result[W-1:HW] == '0); // R11

  AST_FLAG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != 3'd2 |=> flag_out == $past(flag_in)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != 3'd0 |=> !ovf); // R8

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> ovf && result == $past(exp_sat)); // R6

  AST_ROT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 3'd2 && mag == '0 |=> result == $past(opa_fit) && flag_out == $past(flag_in)); // R7
endmodule

bind bsh_unit bsh_unit_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .half(half),
  .flag_in(flag_in), .opa(opa), .out_valid(out_valid), .result(result),
  .flag_out(flag_out), .ovf(ovf), .mag(mag), .sat_evt(sat_evt)
);

// File: tb/tb_bsh_unit.sv
module tb_bsh_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic        half, use_imm, sat, flag_in;
  logic [5:0]  imm_amt, reg_amt;
  logic [31:0] opa, opb;
  logic        out_valid, flag_out, ovf;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bsh_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .half(half),
    .use_imm(use_imm), .imm_amt(imm_amt), .reg_amt(reg_amt), .sat(sat),
    .flag_in(flag_in), .opa(opa), .opb(opb), .out_valid(out_valid),
    .result(result), .flag_out(flag_out), .ovf(ovf)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Bit-serial model built from the requirement text.
  task automatic model(input int o, input bit h, input int amt, input logic [31:0] a,
                       input logic [31:0] b, input bit f, input bit s,
                       output logic [31:0] r, output bit fo, output bit ov);
    int n = h ? 16 : 32;
    logic [63:0] mask = (64'd1 << n) - 1;
    logic [63:0] x = {32'd0, a} & mask;
    logic [63:0] bb = {32'd0, b} & mask;
    bit l = (amt >= 0);
    int m = l ? amt : -amt;
    int k = (m >= 2) ? 2 : 1;
    bit s0 = x[n-1];
    bit nf;
    fo = f; ov = 0;
    case (o)
      0: begin
        for (int i = 0; i < m; i++) begin
          if (l) begin
            x = (x << 1) & mask;
            if (x[n-1] != s0) ov = 1;
          end else begin
            x = (x >> 1) | (64'(s0) << (n-1));
          end
        end
        if (ov && s) x = s0 ? (64'd1 << (n-1)) : (mask >> 1);
      end
      1: for (int i = 0; i < m; i++) x = l ? ((x << 1) & mask) : (x >> 1);
      2: for (int i = 0; i < m; i++) begin
        if (l) begin nf = x[n-1]; x = ((x << 1) & mask) | 64'(fo); end
        else   begin nf = x[0];   x = (x >> 1) | (64'(fo) << (n-1)); end
        fo = nf;
      end
      3: x = ((x << k) + bb) & mask;
      4: x = ((x + bb) << k) & mask;
      default: x = 0;
    endcase
    r = x[31:0];
  endtask

  function automatic string tag(input int o, input bit h, input int amt, input bit ov, input bit s);
    string t;
    case (o)
      0: t = (amt < 0) ? "R4" : ((ov && s) ? "R6" : "R5");
      1: t = "R3";
      2: t = "R7";
      3: t = "R9";
      4: t = "R10";
      default: t = "R8";
    endcase
    return h ? {t, "/R11"} : t;
  endfunction

  task automatic run(input int o, input bit h, input bit ui, input int amt, input int other,
                     input logic [31:0] a, input logic [31:0] b, input bit f, input bit s);
    logic [31:0] er; bit ef, eo; string t;
    @(negedge clk);
    in_valid = 1; op = 3'(o); half = h; use_imm = ui; sat = s; flag_in = f;
    opa = a; opb = b;
    if (ui) begin imm_amt = 6'(amt); reg_amt = 6'(other); end
    else    begin reg_amt = 6'(amt); imm_amt = 6'(other); end
    model(o, h, amt, a, b, f, s, er, ef, eo);
    t = tag(o, h, amt, eo, s);
    @(negedge clk);
    in_valid = 0;
    chk("R1", "out_valid", 32'(out_valid), 32'd1);
    chk(t, $sformatf("result op%0d amt%0d a=%h", o, amt, a), result, er);
    chk((o == 2) ? "R7" : "R8", "flag_out", 32'(flag_out), 32'(ef));
    chk((o == 0) ? "R5" : "R8", "ovf", 32'(ovf), 32'(eo));
  endtask

  initial begin
    logic [31:0] pats [8];
    logic [31:0] keep;
    pats = '{32'h0000B6A3, 32'hABCDEF12, 32'h80000000, 32'h7FFF4001,
             32'hFFFFFFFF, 32'h00000001, 32'h40000000, 32'hC0008000};
    rst_n = 0; in_valid = 0; op = 0; half = 0; use_imm = 0; sat = 0; flag_in = 0;
    imm_amt = 0; reg_amt = 0; opa = 0; opb = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset out_valid", 32'(out_valid), 0);
    chk("R1", "reset result", result, 0);
    chk("R1", "reset flag", 32'(flag_out), 0);
    chk("R1", "reset ovf", 32'(ovf), 0);
    rst_n = 1;

    // Directed examples
    run(1, 0, 1, -4, 0, 32'h0000B6A3, 0, 0, 0);
    chk("R3", "lsr 4", result, 32'h00000B6A);
    run(1, 0, 0, 4, -9, 32'h0000B6A3, 0, 0, 0);
    chk("R3", "lsl 4", result, 32'h000B6A30);
    run(1, 1, 0, 4, 0, 32'h0000B6A3, 0, 0, 0);
    chk("R11", "half lsl 4", result, 32'h00006A30);
    run(2, 0, 1, 4, 0, 32'hABCDEF12, 0, 0, 0);
    chk("R7", "rot 4", result, 32'hBCDEF125);
    chk("R7", "rot 4 flag", 32'(flag_out), 0);
    // R2: the unselected field must not matter
    run(1, 0, 0, -4, 7, 32'h0000B6A3, 0, 0, 0);
    chk("R2", "reg field selected", result, 32'h00000B6A);
    run(1, 0, 1, 4, -9, 32'h0000B6A3, 0, 0, 0);
    chk("R2", "imm field selected", result, 32'h000B6A30);
    run(0, 0, 1, 1, 0, 32'h40000000, 0, 0, 1);
    chk("R6", "sat positive", result, 32'h7FFFFFFF);
    run(0, 0, 1, 2, 0, 32'hA0000000, 0, 0, 1);
    chk("R6", "sat negative", result, 32'h80000000);

    // R1: idle cycles with changing inputs keep outputs
    keep = result;
    @(negedge clk);
    opa = 32'h12345678; op = 3'd1; imm_amt = 6'd3;
    @(negedge clk);
    chk("R1", "hold result", result, keep);
    chk("R1", "idle out_valid", 32'(out_valid), 0);

    // Sweep
    for (int o = 0; o < 6; o++)
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < 2; s++)
          for (int f = 0; f < 2; f++)
            for (int p = 0; p < 8; p++)
              for (int amt = -32; amt < 32; amt++)
                run(o, h[0], amt[0], amt, -amt - 1, pats[p], ~pats[p] ^ 32'h01234567,
                    f[0], s[0]);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule